// File: doc/BRIEF.md
# Row-Hit-First Write Drain Scheduler

This block keeps a short queue of DRAM write requests waiting to go to memory. Each request names a rank, a bank and a row. The memory controller triggers a drain burst when it chooses to flush writes. During a burst the block sends out one write per clock cycle. The burst ends when the queue is empty or when the burst has issued a programmed number of writes, whichever comes first.

On each issue the block looks for a request whose row is already open in its bank. It scans from the oldest entry to the newest and takes the first match. If no request matches, it takes the oldest request. The controller supplies the open-row state of every bank. The issued request leaves the queue. The other requests keep their order of arrival.

Each issued write carries a flag that says whether it hit an open row, so the controller can count row hits. A full flag refuses new requests while the queue is full.

Top module: `wdrain_sched`

## Requirements
- R1: After reset the queue is empty, `enq_full_o` is low, and `iss_valid_o` and `drain_done_o` are low.
- R2: An enqueue is taken on a clock edge when the queue holds fewer than DEPTH entries. `enq_full_o` is high exactly when the queue holds DEPTH entries. A request offered while the queue is full is dropped, even if an issue happens on the same edge.
- R3: If `drain_start_i` is sampled high while no burst is running, a burst starts with its write count at zero. The first issue strobe appears on the following edge. After that the block issues at most one write per edge.
- R4: Before each issue the block compares the burst's write count with `wr_limit_i`, which is held stable during a burst. When the count is greater than or equal to the limit, the burst ends. A limit of zero therefore ends the burst without issuing anything.
- R5: A burst also ends when the queue is empty. The end of a burst is shown by `drain_done_o` high for exactly one cycle, on the edge after the last issue, or after the start edge if nothing was issued.
- R6: The issued request is the oldest queued entry whose row equals the open row of its bank. Bank slot is rank*BANKS+bank. A bank counts as open only when its bit in `open_vld_i` is set, and its open row is field [slot*ROW_W +: ROW_W] of `open_row_i`.
- R7: If no queued entry hits an open row, the oldest entry is issued. This includes the case where the queue holds a single entry.
- R8: Removing an issued entry keeps the order of arrival of all the other entries.
- R9: `iss_hit_o` is high with an issue exactly when the issued row matched the open row of its bank in the cycle the selection was made.
- R10: An enqueue and an issue on the same edge both take effect.
- R11: A `drain_start_i` pulse that arrives while a burst is running is ignored. It does not reset the write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Offer a new write request |
| enq_rank_i | input | RANK_W | Rank of the offered request |
| enq_bank_i | input | BANK_W | Bank of the offered request |
| enq_row_i | input | ROW_W | Row of the offered request |
| enq_full_o | output | 1 | Queue holds DEPTH entries; offers are refused |
| drain_start_i | input | 1 | Start a drain burst |
| wr_limit_i | input | CNT_W | Largest number of writes in one burst |
| open_vld_i | input | RANKS*BANKS | Bank has an open row |
| open_row_i | input | RANKS*BANKS*ROW_W | Open row of each bank |
| iss_valid_o | output | 1 | One write is issued this cycle |
| iss_rank_o | output | RANK_W | Rank of the issued write |
| iss_bank_o | output | BANK_W | Bank of the issued write |
| iss_row_o | output | ROW_W | Row of the issued write |
| iss_hit_o | output | 1 | Issued write hit an open row |
| drain_done_o | output | 1 | Single-cycle pulse at the end of a burst |

## Verification
All outputs are registered. `iss_valid_o`, the issued fields, `iss_hit_o` and `drain_done_o` are the result of the queue, the open-row inputs, the limit and the burst state as they stood just before the edge that updates them. `enq_full_o` follows the queue occupancy that the same edge leaves behind.

The first strobe of a burst therefore comes one edge after the edge that samples `drain_start_i`. The done pulse comes one edge after the last issue.

The bench keeps a reference queue and steps it once per rising edge, using the inputs that were held across that edge. It compares every output 1 ns after the edge. Inputs change only after that comparison, so each check lines up with the edge that produced the value.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } drain_st_e;

   // field width that stays legal when a count of one is configured
   function automatic int field_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/wq_store.sv
// Age-ordered write queue: slot 0 is the oldest entry; a removal anywhere
// closes the gap by shifting younger entries down one slot.
module wq_store #(
   parameter int DEPTH = 8,
   parameter int ENT_W = 11,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [ENT_W-1:0] push_data_i,
   input  logic             pop_i,
   input  logic [IDX_W-1:0] pop_idx_i,
   output logic [ENT_W-1:0] ent_o [DEPTH],
   output logic [CW-1:0]    count_o
);

   logic [ENT_W-1:0] slot_q     [DEPTH];
   logic [ENT_W-1:0] slot_d     [DEPTH];
   logic [ENT_W-1:0] slot_above [DEPTH];
   logic [CW-1:0]    count_q;
   logic [CW-1:0]    count_d;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         if (g == DEPTH - 1) begin : g_top
            assign slot_above[g] = slot_q[g];
         end else begin : g_mid
            assign slot_above[g] = slot_q[g+1];
         end
         assign ent_o[g] = slot_q[g];
      end
   endgenerate

   always_comb begin
      count_d = count_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (pop_i && (IDX_W'(i) >= pop_idx_i)) begin
            slot_d[i] = slot_above[i];
         end else begin
            slot_d[i] = slot_q[i];
         end
      end
      if (pop_i) begin
         count_d = count_q - CW'(1);
      end
      if (push_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == count_d) begin
               slot_d[i] = push_data_i;
            end
         end
         count_d = count_d + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= '0;
         end
      end else begin
         count_q <= count_d;
         for (int i = 0; i < DEPTH; i++) begin
            slot_q[i] <= slot_d[i];
         end
      end
   end

   assign count_o = count_q;

endmodule

// File: rtl/wq_hit_finder.sv
// Compares every live entry against the open row of its bank and returns
// the lowest (oldest) matching slot.
module wq_hit_finder #(
   parameter int DEPTH  = 8,
   parameter int ROW_W  = 8,
   parameter int NB     = 8,
   parameter int BIDX_W = 3,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0]       count_i,
   input  logic [BIDX_W-1:0]   ent_bidx_i [DEPTH],
   input  logic [ROW_W-1:0]    ent_row_i  [DEPTH],
   input  logic [NB-1:0]       open_vld_i,
   input  logic [NB*ROW_W-1:0] open_row_i,
   output logic                found_o,
   output logic [IDX_W-1:0]    hit_idx_o
);

   logic [DEPTH-1:0] hit_vec;

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cmp
         logic live;
         logic in_range;
         assign live     = (CW'(g) < count_i);
         assign in_range = ({1'b0, ent_bidx_i[g]} < (BIDX_W+1)'(NB));
         assign hit_vec[g] = live && in_range &&
                             open_vld_i[ent_bidx_i[g]] &&
                             (open_row_i[ent_bidx_i[g]*ROW_W +: ROW_W] == ent_row_i[g]);
      end
   endgenerate

   always_comb begin
      found_o   = 1'b0;
      hit_idx_o = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            found_o   = 1'b1;
            hit_idx_o = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/wdrain_sched.sv
module wdrain_sched
   import wdrain_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int RANKS = 2,
   parameter int BANKS = 4,
   parameter int ROW_W = 8,
   parameter int CNT_W = 4,
   localparam int RANK_W = field_w(RANKS),
   localparam int BANK_W = field_w(BANKS),
   localparam int NB     = RANKS * BANKS,
   localparam int BIDX_W = field_w(NB),
   localparam int ENT_W  = RANK_W + BANK_W + ROW_W,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid_i,
   input  logic [RANK_W-1:0] enq_rank_i,
   input  logic [BANK_W-1:0] enq_bank_i,
   input  logic [ROW_W-1:0]  enq_row_i,
   output logic              enq_full_o,
   input  logic              drain_start_i,
   input  logic [CNT_W-1:0]  wr_limit_i,
   input  logic [NB-1:0]     open_vld_i,
   input  logic [NB*ROW_W-1:0] open_row_i,
   output logic              iss_valid_o,
   output logic [RANK_W-1:0] iss_rank_o,
   output logic [BANK_W-1:0] iss_bank_o,
   output logic [ROW_W-1:0]  iss_row_o,
   output logic              iss_hit_o,
   output logic              drain_done_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("wdrain_sched: DEPTH must be at least 2");
      end
      if (NB < 2) begin : g_bad_banks
         $error("wdrain_sched: RANKS*BANKS must be at least 2");
      end
      if (ROW_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("wdrain_sched: ROW_W and CNT_W must be positive");
      end
   endgenerate

   drain_st_e          st_q;
   logic [CNT_W-1:0]   burst_cnt_q;
   logic [CW-1:0]      q_count;
   logic [ENT_W-1:0]   ent     [DEPTH];
   logic [BIDX_W-1:0]  ent_bidx[DEPTH];
   logic [ROW_W-1:0]   ent_row [DEPTH];
   logic               hit_found;
   logic [IDX_W-1:0]   hit_idx;
   logic [IDX_W-1:0]   sel_idx;
   logic [ENT_W-1:0]   sel_ent;
   logic               sel_hit;
   logic               can_issue;
   logic               push;
   logic               pop;

   // entry layout: {rank, bank, row}
   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_unpack
         logic [RANK_W-1:0] e_rank;
         logic [BANK_W-1:0] e_bank;
         assign e_rank      = ent[g][ENT_W-1 -: RANK_W];
         assign e_bank      = ent[g][ROW_W+BANK_W-1 -: BANK_W];
         assign ent_row[g]  = ent[g][ROW_W-1:0];
         assign ent_bidx[g] = BIDX_W'(e_rank) * BIDX_W'(BANKS) + BIDX_W'(e_bank);
      end
   endgenerate

   assign enq_full_o = (q_count == CW'(DEPTH));
   assign push       = enq_valid_i && !enq_full_o;
   assign can_issue  = (st_q == ST_DRAIN) && (q_count != '0) && (burst_cnt_q < wr_limit_i);
   assign pop        = can_issue;

   wq_store #(
      .DEPTH (DEPTH),
      .ENT_W (ENT_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i ({enq_rank_i, enq_bank_i, enq_row_i}),
      .pop_i       (pop),
      .pop_idx_i   (sel_idx),
      .ent_o       (ent),
      .count_o     (q_count)
   );

   wq_hit_finder #(
      .DEPTH  (DEPTH),
      .ROW_W  (ROW_W),
      .NB     (NB),
      .BIDX_W (BIDX_W)
   ) u_find (
      .count_i    (q_count),
      .ent_bidx_i (ent_bidx),
      .ent_row_i  (ent_row),
      .open_vld_i (open_vld_i),
      .open_row_i (open_row_i),
      .found_o    (hit_found),
      .hit_idx_o  (hit_idx)
   );

   // a lone entry is taken straight from the head; otherwise the oldest
   // hit wins, falling back to the head
   always_comb begin
      if (q_count == CW'(1)) begin
         sel_idx = '0;
      end else if (hit_found) begin
         sel_idx = hit_idx;
      end else begin
         sel_idx = '0;
      end
      sel_ent = ent[sel_idx];
      sel_hit = hit_found && (hit_idx == sel_idx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         burst_cnt_q  <= '0;
         iss_valid_o  <= 1'b0;
         iss_rank_o   <= '0;
         iss_bank_o   <= '0;
         iss_row_o    <= '0;
         iss_hit_o    <= 1'b0;
         drain_done_o <= 1'b0;
      end else begin
         iss_valid_o  <= 1'b0;
         iss_hit_o    <= 1'b0;
         drain_done_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (drain_start_i) begin
                  st_q        <= ST_DRAIN;
                  burst_cnt_q <= '0;
               end
            end
            ST_DRAIN: begin
               if (can_issue) begin
                  iss_valid_o <= 1'b1;
                  iss_rank_o  <= sel_ent[ENT_W-1 -: RANK_W];
                  iss_bank_o  <= sel_ent[ROW_W+BANK_W-1 -: BANK_W];
                  iss_row_o   <= sel_ent[ROW_W-1:0];
                  iss_hit_o   <= sel_hit;
                  burst_cnt_q <= burst_cnt_q + CNT_W'(1);
               end else begin
                  drain_done_o <= 1'b1;
                  st_q         <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/wdrain_sched_chk.sv
module wdrain_sched_chk
   import wdrain_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int RANKS = 2,
   parameter int BANKS = 4,
   parameter int ROW_W = 8,
   parameter int CNT_W = 4,
   localparam int RANK_W = field_w(RANKS),
   localparam int BANK_W = field_w(BANKS),
   localparam int NB     = RANKS * BANKS,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enq_valid_i,
   input logic [CNT_W-1:0]  wr_limit_i,
   input logic [NB-1:0]     open_vld_i,
   input logic [NB*ROW_W-1:0] open_row_i,
   input logic              iss_valid_o,
   input logic [RANK_W-1:0] iss_rank_o,
   input logic [BANK_W-1:0] iss_bank_o,
   input logic [ROW_W-1:0]  iss_row_o,
   input logic              iss_hit_o,
   input logic              drain_done_o,
   input logic [CW-1:0]     q_count,
   input logic [CNT_W-1:0]  burst_cnt_q
);

   logic [NB-1:0]       ov_q;
   logic [NB*ROW_W-1:0] orow_q;
   int                  slot;
   logic                exp_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_q   <= '0;
         orow_q <= '0;
      end else begin
         ov_q   <= open_vld_i;
         orow_q <= open_row_i;
      end
   end

   always_comb begin
      slot    = int'(iss_rank_o) * BANKS + int'(iss_bank_o);
      exp_hit = 1'b0;
      if (slot < NB) begin
         exp_hit = ov_q[slot] && (orow_q[slot*ROW_W +: ROW_W] == iss_row_o);
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));                                          // R2

   AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == CW'(DEPTH) && enq_valid_i) |=>
      (q_count == (iss_valid_o ? CW'(DEPTH - 1) : CW'(DEPTH))));      // R2

   AST_ISS_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid_o |-> $past(q_count) != '0);                           // R3

   AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid_o |-> burst_cnt_q <= wr_limit_i);                      // R4

   AST_DONE_REASON: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done_o |-> ($past(q_count) == '0 || $past(burst_cnt_q) >= $past(wr_limit_i))); // R4

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done_o |=> !drain_done_o);                                 // R5

   AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid_o |-> (iss_hit_o == exp_hit));                         // R9

endmodule

bind wdrain_sched wdrain_sched_chk #(
   .DEPTH (DEPTH),
   .RANKS (RANKS),
   .BANKS (BANKS),
   .ROW_W (ROW_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enq_valid_i  (enq_valid_i),
   .wr_limit_i   (wr_limit_i),
   .open_vld_i   (open_vld_i),
   .open_row_i   (open_row_i),
   .iss_valid_o  (iss_valid_o),
   .iss_rank_o   (iss_rank_o),
   .iss_bank_o   (iss_bank_o),
   .iss_row_o    (iss_row_o),
   .iss_hit_o    (iss_hit_o),
   .drain_done_o (drain_done_o),
   .q_count      (q_count),
   .burst_cnt_q  (burst_cnt_q)
);

// File: tb/wdrain_sched_tb.sv
module wdrain_sched_tb;
   import wdrain_pkg::*;

   localparam int DEPTH  = 8;
   localparam int RANKS  = 2;
   localparam int BANKS  = 4;
   localparam int ROW_W  = 8;
   localparam int CNT_W  = 4;
   localparam int RANK_W = field_w(RANKS);
   localparam int BANK_W = field_w(BANKS);
   localparam int NB     = RANKS * BANKS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enq_valid_i = 1'b0;
   logic [RANK_W-1:0] enq_rank_i = '0;
   logic [BANK_W-1:0] enq_bank_i = '0;
   logic [ROW_W-1:0]  enq_row_i = '0;
   logic              enq_full_o;
   logic              drain_start_i = 1'b0;
   logic [CNT_W-1:0]  wr_limit_i = '0;
   logic [NB-1:0]     open_vld_i = '0;
   logic [NB*ROW_W-1:0] open_row_i = '0;
   logic              iss_valid_o;
   logic [RANK_W-1:0] iss_rank_o;
   logic [BANK_W-1:0] iss_bank_o;
   logic [ROW_W-1:0]  iss_row_o;
   logic              iss_hit_o;
   logic              drain_done_o;

   always #10 clk = ~clk;   // 50 MHz

   wdrain_sched #(
      .DEPTH (DEPTH), .RANKS (RANKS), .BANKS (BANKS), .ROW_W (ROW_W), .CNT_W (CNT_W)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .enq_valid_i (enq_valid_i), .enq_rank_i (enq_rank_i),
      .enq_bank_i (enq_bank_i), .enq_row_i (enq_row_i), .enq_full_o (enq_full_o),
      .drain_start_i (drain_start_i), .wr_limit_i (wr_limit_i),
      .open_vld_i (open_vld_i), .open_row_i (open_row_i),
      .iss_valid_o (iss_valid_o), .iss_rank_o (iss_rank_o), .iss_bank_o (iss_bank_o),
      .iss_row_o (iss_row_o), .iss_hit_o (iss_hit_o), .drain_done_o (drain_done_o)
   );

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   // reference queue, index 0 oldest
   int m_rank [DEPTH];
   int m_bank [DEPTH];
   int m_row  [DEPTH];
   int m_n    = 0;
   bit m_drain = 0;
   int m_cnt  = 0;

   // issue log for directed scenarios
   int lg_row [64];
   int lg_hit [64];
   int lg_n   = 0;
   int dones  = 0;

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit m_hit(input int i);
      int s;
      s = m_rank[i] * BANKS + m_bank[i];
      return open_vld_i[s] && (int'(open_row_i[s*ROW_W +: ROW_W]) == m_row[i]);
   endfunction

   task automatic summary_and_end();
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary_and_end();
      end
   end

   // one rising edge: step the reference, then compare the outputs
   task automatic tick();
      bit ev, ed, eh;
      int sel, pre;
      @(posedge clk);
      #1;
      ev = 0; ed = 0; eh = 0; sel = 0;
      pre = m_n;
      if (m_drain) begin
         if (m_n != 0 && m_cnt < int'(wr_limit_i)) begin
            for (int i = 0; i < m_n; i++) begin
               if (!eh && m_hit(i)) begin
                  eh = 1; sel = i;
               end
            end
            ev = 1;
            chk("R6 issued rank", int'(iss_rank_o), m_rank[sel]);
            chk("R6 issued bank", int'(iss_bank_o), m_bank[sel]);
            chk("R6/R7 issued row", int'(iss_row_o), m_row[sel]);
            chk("R9 hit flag", int'(iss_hit_o), int'(eh));
            for (int i = sel; i < m_n - 1; i++) begin
               m_rank[i] = m_rank[i+1];
               m_bank[i] = m_bank[i+1];
               m_row[i]  = m_row[i+1];
            end
            m_n--;
            m_cnt++;
         end else begin
            ed = 1;
            m_drain = 0;
         end
      end else if (drain_start_i) begin
         m_drain = 1;
         m_cnt = 0;
      end
      if (enq_valid_i && pre < DEPTH) begin
         m_rank[m_n] = int'(enq_rank_i);
         m_bank[m_n] = int'(enq_bank_i);
         m_row[m_n]  = int'(enq_row_i);
         m_n++;
      end
      chk("R3 issue strobe", int'(iss_valid_o), int'(ev));
      chk("R4/R5 done pulse", int'(drain_done_o), int'(ed));
      chk("R2 full flag", int'(enq_full_o), int'(m_n == DEPTH));
      if (iss_valid_o && lg_n < 64) begin
         lg_row[lg_n] = int'(iss_row_o);
         lg_hit[lg_n] = int'(iss_hit_o);
         lg_n++;
      end
      if (drain_done_o) dones++;
   endtask

   task automatic enq(input int r, input int b, input int w);
      enq_valid_i = 1'b1;
      enq_rank_i  = RANK_W'(r);
      enq_bank_i  = BANK_W'(b);
      enq_row_i   = ROW_W'(w);
      tick();
      enq_valid_i = 1'b0;
   endtask

   task automatic set_open(input int s, input bit v, input int w);
      open_vld_i[s] = v;
      open_row_i[s*ROW_W +: ROW_W] = ROW_W'(w);
   endtask

   task automatic start_drain(input int lim);
      wr_limit_i    = CNT_W'(lim);
      drain_start_i = 1'b1;
      tick();
      drain_start_i = 1'b0;
   endtask

   task automatic run_to_done();
      int d0;
      d0 = dones;
      for (int k = 0; k < 40; k++) begin
         if (dones != d0) break;
         tick();
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0417));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset strobe", int'(iss_valid_o), 0);
      chk("R1 reset done", int'(drain_done_o), 0);
      chk("R1 reset full", int'(enq_full_o), 0);
      rst_n = 1'b1;
      tick();

      // oldest hit first, then oldest miss, order kept
      set_open(0, 1, 9);          // rank0 bank0 open row 9
      set_open(3, 1, 4);          // rank0 bank3 open row 4
      enq(0, 1, 1);
      enq(0, 0, 5);
      enq(0, 3, 4);
      enq(0, 0, 9);
      lg_n = 0;
      start_drain(8);
      run_to_done();
      chk("R6 issue count", lg_n, 4);
      chk("R6 oldest hit first", lg_row[0], 4);
      chk("R6 second hit", lg_row[1], 9);
      chk("R7 oldest miss", lg_row[2], 1);
      chk("R8 order kept", lg_row[3], 5);
      chk("R9 hit flag on hit", lg_hit[0], 1);
      chk("R9 hit flag on miss", lg_hit[2], 0);
      open_vld_i = '0;

      // limit reached, restart during burst ignored
      for (int i = 0; i < 4; i++) enq(1, 2, 30 + i);
      lg_n = 0;
      start_drain(2);
      drain_start_i = 1'b1;
      tick();
      drain_start_i = 1'b0;
      run_to_done();
      chk("R4 burst stops at limit", lg_n, 2);
      chk("R11 restart ignored", lg_n, 2);
      lg_n = 0;
      start_drain(0);
      run_to_done();
      chk("R4 zero limit issues nothing", lg_n, 0);
      lg_n = 0;
      start_drain(15);
      run_to_done();
      chk("R5 stops when empty", lg_n, 2);
      chk("R8 remaining order", lg_row[1], 33);

      // fill past full
      for (int i = 0; i < DEPTH + 2; i++) enq(0, 1, i);
      chk("R2 full at depth", int'(enq_full_o), 1);
      lg_n = 0;
      start_drain(15);
      run_to_done();
      chk("R2 extra offers dropped", lg_n, DEPTH);
      chk("R2 last kept entry", lg_row[DEPTH-1], DEPTH - 1);

      // enqueue while issuing
      enq(1, 1, 10);
      enq(1, 1, 11);
      lg_n = 0;
      start_drain(15);
      for (int i = 0; i < 3; i++) begin
         enq_valid_i = 1'b1;
         enq_rank_i  = 1'b1;
         enq_bank_i  = 2'd1;
         enq_row_i   = ROW_W'(20 + i);
         tick();
      end
      enq_valid_i = 1'b0;
      run_to_done();
      chk("R10 enqueue during issue", lg_n, 5);
      chk("R10 last issued row", lg_row[4], 22);

      // random traffic
      for (int c = 0; c < 4000; c++) begin
         enq_valid_i = ($urandom % 3) == 0;
         enq_rank_i  = RANK_W'($urandom % RANKS);
         enq_bank_i  = BANK_W'($urandom % BANKS);
         enq_row_i   = ROW_W'($urandom % 4);
         if (($urandom % 6) == 0) begin
            int s;
            s = int'($urandom % NB);
            set_open(s, bit'($urandom % 4 != 0), int'($urandom % 4));
         end
         if (!m_drain && !drain_start_i) wr_limit_i = CNT_W'($urandom % 7);
         drain_start_i = ($urandom % 8) == 0;
         tick();
      end
      drain_start_i = 1'b0;
      enq_valid_i   = 1'b0;
      repeat (3) tick();

      summary_and_end();
   end

endmodule